// File: doc/BRIEF.md
# 8x8 Shift-Register Transpose Buffer

This block sits between two one-dimensional transform stages and turns an 8x8 block of 14-bit values on its side. The upstream stage offers one row of eight values per clock. The values pass into a grid of 64 registers. When the grid is full it empties downward, one set of eight values per clock, and each set that leaves is one column of the block that went in. The values are never interpreted, so the block does not care whether they are signed or what their scale is.

A small controller has two states. In `FILL`, each clock with `in_vld` high accepts a row, and every stored value moves one cell to the left. `FILL` loops on itself until the eighth row is accepted. That edge takes the controller to `DRAIN`. In `DRAIN` every cell moves one cell down, the bottom row is presented at the output, and `busy` tells the producer that anything it offers is dropped. `DRAIN` loops on itself for eight output cycles. On the edge that ends the eighth output cycle, it returns to `FILL`. The buffer runs on the same clock as the transform datapath.

Top module: `xpose_buffer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_vld` and `busy` are low and `out_data` is zero.
- R2: A row is accepted on each rising edge where `in_vld` is high and `busy` is low. Lane j of the row is `in_data[j*14 +: 14]`.
- R3: In the cycle after the edge that accepts the eighth row of a block, `out_vld` and `busy` are high and output set 0 is presented.
- R4: In the r-th valid output cycle (r counted from 0), lane c of `out_data` (bits `[c*14 +: 14]`) equals lane r of the c-th accepted row (c counted from 0). That is, output set r is input column r.
- R5: `out_vld` stays high for exactly eight consecutive cycles per block, then falls.
- R6: A row offered while `busy` is high is ignored. It neither shows up in later output nor counts toward the next block.
- R7: `out_data` is all zeros in every cycle where `out_vld` is low.
- R8: Cycles with `in_vld` low during filling leave the stored rows in place, and a block may be loaded with any gaps between its rows.
- R9: Values pass through bit-exact, including all-ones and sign-bit-only patterns.
- R10: A row offered in the cycle right after the last valid output cycle is accepted as row 0 of the next block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the transform datapath |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | A row is offered on `in_data` |
| in_data | input | 112 | Eight 14-bit lanes of one input row, lane 0 in the low bits |
| busy | output | 1 | High while draining; offered rows are dropped |
| out_vld | output | 1 | `out_data` carries one output set |
| out_data | output | 112 | Eight 14-bit lanes of one output set (one input column) |

## Verification
The checker enforces the following properties on every cycle:
- `out_vld` may rise only after an eighth accepted row (R3).
- A valid run is never longer than eight cycles and always lasts exactly eight (R5).
- The output is zero while idle (R7).

Only the bench's scenarios can show the following. The cycle-by-cycle queue model finds these by comparison:
- That each output set really is the matching input column (R4, R9).
- That rows offered during draining leave no trace (R6).
- That gaps while filling do not disturb stored rows (R8).
- That a row offered right after draining starts the next block (R10).

// File: rtl/xpose_pkg.sv
package xpose_pkg;

    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_DRAIN = 1'b1
    } xp_state_e;

    typedef enum logic [1:0] {
        MV_HOLD = 2'd0,
        MV_LEFT = 2'd1,
        MV_DOWN = 2'd2
    } xp_move_e;

endpackage

// File: rtl/xpose_ctrl.sv
module xpose_ctrl
    import xpose_pkg::*;
#(
    parameter int DIM = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_vld,
    output xp_move_e move,
    output logic     draining
);
    localparam int CW = (DIM > 1) ? $clog2(DIM) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIM - 1);

    xp_state_e      state, state_n;
    logic [CW-1:0]  cnt, cnt_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FILL;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            ST_FILL: begin
                if (in_vld) begin
                    if (cnt == LAST) begin
                        state_n = ST_DRAIN;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                if (cnt == LAST) begin
                    state_n = ST_FILL;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        move     = MV_HOLD;
        draining = 1'b0;
        unique case (state)
            ST_FILL: begin
                if (in_vld) move = MV_LEFT;
            end
            ST_DRAIN: begin
                move     = MV_DOWN;
                draining = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/xpose_cell.sv
module xpose_cell
    import xpose_pkg::*;
#(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  xp_move_e     move,
    input  logic [W-1:0] from_right,
    input  logic [W-1:0] from_above,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (move)
                MV_LEFT: q <= from_right;
                MV_DOWN: q <= from_above;
                MV_HOLD: q <= q;
                default: q <= q;
            endcase
        end
    end
endmodule

// File: rtl/xpose_grid.sv
module xpose_grid
    import xpose_pkg::*;
#(
    parameter int DIM = 8,
    parameter int W   = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  xp_move_e         move,
    input  logic [DIM*W-1:0] lanes,
    output logic [DIM*W-1:0] bottom
);
    logic [W-1:0] q [DIM][DIM];

    for (genvar g = 0; g < DIM; g++) begin : g_row
        for (genvar c = 0; c < DIM; c++) begin : g_col
            logic [W-1:0] rt;
            logic [W-1:0] up;

            // grid row g is fed by input lane DIM-1-g, so lane 0 reaches the bottom
            if (c == DIM - 1) begin : g_edge
                assign rt = lanes[(DIM-1-g)*W +: W];
            end else begin : g_inner
                assign rt = q[g][c+1];
            end

            if (g == 0) begin : g_top
                assign up = '0;
            end else begin : g_below
                assign up = q[g-1][c];
            end

            xpose_cell #(.W(W)) i_cell (
                .clk        (clk),
                .rst_n      (rst_n),
                .move       (move),
                .from_right (rt),
                .from_above (up),
                .q          (q[g][c])
            );
        end
    end

    for (genvar c = 0; c < DIM; c++) begin : g_out
        assign bottom[c*W +: W] = q[DIM-1][c];
    end
endmodule

// File: rtl/xpose_buffer.sv
module xpose_buffer
    import xpose_pkg::*;
#(
    parameter int DIM = 8,
    parameter int W   = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [DIM*W-1:0] in_data,
    output logic             busy,
    output logic             out_vld,
    output logic [DIM*W-1:0] out_data
);
    xp_move_e         move;
    logic             draining;
    logic [DIM*W-1:0] bottom;

    xpose_ctrl #(.DIM(DIM)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .move     (move),
        .draining (draining)
    );

    xpose_grid #(.DIM(DIM), .W(W)) i_grid (
        .clk    (clk),
        .rst_n  (rst_n),
        .move   (move),
        .lanes  (in_data),
        .bottom (bottom)
    );

    always_comb begin
        busy     = draining;
        out_vld  = draining;
        out_data = draining ? bottom : '0;
    end
endmodule

// File: rtl/xpose_buffer_chk.sv
module xpose_buffer_chk #(
    parameter int DIM = 8,
    parameter int W   = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic             busy,
    input logic             out_vld,
    input logic [DIM*W-1:0] out_data
);
    localparam int KW = $clog2(DIM) + 1;

    logic [KW-1:0] lcnt;
    logic [KW-1:0] ocnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcnt <= '0;
            ocnt <= '0;
        end else begin
            if (in_vld && !busy)
                lcnt <= (lcnt == KW'(DIM - 1)) ? '0 : lcnt + 1'b1;
            ocnt <= out_vld ? ocnt + 1'b1 : '0;
        end
    end

    // R3: valid output only starts after the eighth accepted row
    a_r3_start_after_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_vld) |-> ($past(lcnt) == KW'(DIM - 1) && $past(in_vld) && !$past(busy)));

    // R5: a valid run ends after exactly DIM cycles
    a_r5_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_vld) |-> $past(ocnt) == KW'(DIM - 1));

    // R5: a valid run never exceeds DIM cycles
    a_r5_no_overlong: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ocnt < KW'(DIM));

    // R7: idle output is zero
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> out_data == '0);

    // R6: busy only rises right after an offered row
    a_r6_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(in_vld));
endmodule

bind xpose_buffer xpose_buffer_chk #(.DIM(DIM), .W(W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .busy     (busy),
    .out_vld  (out_vld),
    .out_data (out_data)
);

// File: tb/test_xpose_buffer.sv
`timescale 1ns/1ps
module test_xpose_buffer;
    localparam int DIM = 8;
    localparam int W   = 14;
    localparam int BW  = DIM * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld = 1'b0;
    logic [BW-1:0] in_data = '0;
    logic          busy;
    logic          out_vld;
    logic [BW-1:0] out_data;

    int    n_cmp  = 0;
    int    n_bad  = 0;
    string tag    = "R1";

    always #2 clk = ~clk;

    xpose_buffer #(.DIM(DIM), .W(W)) i_xpose_buffer (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .in_data  (in_data),
        .busy     (busy),
        .out_vld  (out_vld),
        .out_data (out_data)
    );

    // behavioural reference: rows collected, then columns queued for output
    logic [BW-1:0] fillq [$];
    logic [BW-1:0] outq  [$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fillq.delete();
            outq.delete();
        end else if (outq.size() > 0) begin
            void'(outq.pop_front());
        end else if (in_vld) begin
            fillq.push_back(in_data);
            if (fillq.size() == DIM) begin
                for (int r = 0; r < DIM; r++) begin
                    logic [BW-1:0] col;
                    col = '0;
                    for (int c = 0; c < DIM; c++)
                        col[c*W +: W] = fillq[c][r*W +: W];
                    outq.push_back(col);
                end
                fillq.delete();
            end
        end
    end

    task automatic check(input string t, input string what,
                         input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic          ev;
            logic [BW-1:0] ed;
            ev = (outq.size() > 0);
            ed = ev ? outq[0] : '0;
            check(tag, "out_vld", BW'(out_vld), BW'(ev));
            check(tag, "busy",    BW'(busy),    BW'(ev));
            check(ev ? tag : "R7", "out_data", out_data, ed);
        end
    end

    function automatic logic [BW-1:0] mk_row(input int seed);
        logic [BW-1:0] v;
        for (int j = 0; j < DIM; j++)
            v[j*W +: W] = W'((seed * DIM + j) * 97 + 3);
        return v;
    endfunction

    task automatic drive(input logic v, input logic [BW-1:0] d);
        in_vld  = v;
        in_data = d;
        @(negedge clk);
    endtask

    task automatic count_run(input string t);
        int n;
        n = 0;
        in_vld = 1'b0;
        while (out_vld && n < 20) begin
            n++;
            @(negedge clk);
        end
        check(t, "valid run length", BW'(n), BW'(DIM));
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R5 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state, during and after reset
        repeat (3) @(negedge clk);
        check("R1", "out_vld in reset", BW'(out_vld), '0);
        check("R1", "out_data in reset", out_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy after reset", BW'(busy), '0);

        // R2 / R4 / R3 / R5: plain block, columns out as rows
        tag = "R4";
        for (int k = 0; k < DIM; k++) drive(1'b1, mk_row(k));
        check("R3", "out_vld after eighth row", BW'(out_vld), BW'(1));
        count_run("R5");

        // R8: gaps between rows while filling
        tag = "R8";
        for (int k = 0; k < DIM; k++) begin
            drive(1'b1, mk_row(20 + k));
            if (k % 2 == 0) drive(1'b0, mk_row(999));
            if (k == 3) repeat (3) drive(1'b0, '1);
        end
        count_run("R8");

        // R9: bit-exact extremes
        tag = "R9";
        for (int k = 0; k < DIM; k++)
            drive(1'b1, (k % 2 == 0) ? {BW{1'b1}} : {DIM{1'b1, {(W-1){1'b0}}}});
        count_run("R9");

        // R6 / R10: offer rows every cycle; drain ignores them, next block starts at once
        tag = "R6";
        for (int k = 0; k < 3 * DIM + 4; k++) begin
            if (k >= 2 * DIM) tag = "R10";
            drive(1'b1, mk_row(100 + k));
        end
        in_vld = 1'b0;
        repeat (2 * DIM + 4) @(negedge clk);
        check("R10", "idle after drain", BW'(out_vld), '0);

        tag = "R7";
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule